// File: doc/BRIEF.md
# Crypto Control Packet Decoder

This block sits between a descriptor fetch engine and a cipher core. It takes a valid/ready stream of 32-bit words. The first beat of each packet carries a start-of-packet marker and a 10-bit type flag word. Bit 0 of the flags tells the two packet kinds apart. A control packet carries configuration in-band: an operation-mode header, a cipher length word, an initialisation vector and key words. Which of these are present, and where the key words land, is set by the packet's own flag bits.

Configuration is built up in shadow registers while a control packet streams in. It moves into the registers that the cipher core reads in one step, at the end of a packet that is well formed and has a legal operation mode. A data packet is forwarded combinationally to the cipher datapath, with the process id of the active configuration attached. A data packet that arrives before any configuration exists is consumed and dropped, and the block flags a protocol error. A control packet with the wrong word count is discarded, and the block flags a malformed packet.

Top module: `ctrlpkt_decoder`

## Requirements
- R1: With a configuration active, a data packet (type bit 0 clear on its start beat) is forwarded in the same cycle, with the same words, a start marker on its first word only and an end marker on its last word. `outProcId` shows header bits 7:0 of the active configuration, and `inReady` follows `outReady`.
- R2: When type bit 1 is set, word 0 of a control packet is the header and word 1 is the length word. After a valid commit, `cfgHeader` shows the header. `cfgAlgLen` shows bits 15:0 of the length word and `cfgHdrLen` shows bits 31:16.
- R3: When type bit 3 is set, the next four words after the header/length pair (or from word 0 if there is no such pair) load IV words 0..3, with `cfgIv[32*i+:32]` holding word i.
- R4: Key words come last and load consecutive key slots (`cfgKey[32*i+:32]` holds slot i). The lowest set flag picks the first slot: bit 4 picks slot 0, bit 5 picks slot 4 and bit 6 picks slot 6. Slots that are not written keep their earlier values.
- R5: Header bits 23:20 hold the key size code. Codes 4, 6 and 8 let key slots be written up to that slot count, and any other code allows no key words. The size comes from this packet's header if it has one, and otherwise from the active configuration.
- R6: A control packet must hold exactly the words that its flags imply. Flag bits 2, 7, 8 and 9 add no words. If the count is wrong, `malformErr` pulses once in the cycle after the end beat, and the configuration stays as it was. The configuration outputs never change before the cycle after a control packet's end beat.
- R7: Header bits 31:28 are the op mode. Value 1 means encrypt and value 3 means decrypt, shown on `cfgDecrypt`. A well-formed control packet with any other op mode pulses `protoErr` once and commits nothing. `cfgValid` rises on the first commit and stays high.
- R8: A data packet that arrives while `cfgValid` is low is accepted with `inReady` high throughout. It produces no output, and `protoErr` pulses once in the cycle after its start beat.
- R9: Control packets never appear on the output, and `inReady` stays high throughout them.
- R10: After reset, `cfgValid`, `outValid`, `protoErr` and `malformErr` are low, and all configuration registers are zero.
- R11: A word that arrives with no start marker while no packet is open is consumed and pulses `malformErr` once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Input word accepted |
| inSop | input | 1 | First word of a packet |
| inEop | input | 1 | Last word of a packet |
| inType | input | 10 | Packet type flags, sampled with inSop |
| inData | input | 32 | Input word |
| outValid | output | 1 | Forwarded data word valid |
| outReady | input | 1 | Cipher datapath ready |
| outSop | output | 1 | First forwarded word of a packet |
| outEop | output | 1 | Last forwarded word of a packet |
| outData | output | 32 | Forwarded data word |
| outProcId | output | 8 | Process id of the active configuration |
| cfgValid | output | 1 | A configuration has been committed |
| cfgHeader | output | 32 | Active operation-mode header |
| cfgAlgLen | output | 16 | Active algorithm length |
| cfgHdrLen | output | 16 | Active header length |
| cfgDecrypt | output | 1 | Active op mode is decrypt |
| cfgIv | output | 128 | Active IV words |
| cfgKey | output | 256 | Active key slots |
| protoErr | output | 1 | Protocol error pulse |
| malformErr | output | 1 | Malformed packet pulse |

## Verification
Directed control packets cover each section on its own: header only, IV plus key from slot 0, key from slot 4 with both slot-4 and slot-6 flags set, and a slot-6 start with a 6-word key that implies no key words. These show whether the slot offset, the priority and the size cap each take effect. Packets one word short, one word long and with an illegal op mode show that a rejected packet leaves every configuration output as it was, and show which of the two error pulses it raises. Random control packets with random flags, key sizes, op modes and word counts are mixed with data packets of random length under random back-pressure. Checking the forwarded words, the markers and the process id separates correct forwarding from stalls and from leaks of control words.

// File: rtl/ctrldec_pkg.sv
package ctrldec_pkg;
  localparam int WORD_W    = 32;
  localparam int FLAG_W    = 10;
  localparam int KEY_WORDS = 8;
  localparam int IV_WORDS  = 4;
  localparam int CNT_W     = 5;
  localparam int KIDX_W    = $clog2(KEY_WORDS);
  localparam int VIDX_W    = $clog2(IV_WORDS);

  // type flag bit positions
  localparam int FL_CTRL   = 0;
  localparam int FL_CIPHER = 1;
  localparam int FL_IV     = 3;
  localparam int FL_KEYA   = 4;
  localparam int FL_KEYB   = 5;
  localparam int FL_KEYC   = 6;
  localparam int KEYB_SLOT = 4;
  localparam int KEYC_SLOT = 6;

  // header field positions
  localparam int KSZ_LO = 20;
  localparam int OPM_LO = 28;

  localparam logic [3:0] OPM_ENC = 4'h1;
  localparam logic [3:0] OPM_DEC = 4'h3;

  typedef enum logic [1:0] {S_IDLE, S_CTRL, S_DATA, S_DROP} state_t;

  typedef struct packed {
    logic              snap;
    logic              wrHdr;
    logic              wrLen;
    logic              wrIv;
    logic              wrKey;
    logic [KIDX_W-1:0] idx;
    logic              commit;
  } strobe_t;
endpackage

// File: rtl/ctrldec_ctrl.sv
module ctrldec_ctrl
  import ctrldec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inEop,
  input  logic [FLAG_W-1:0] inType,
  input  logic              outReady,
  input  logic              cfgValid,
  input  logic [3:0]        cfgKeySize,
  input  logic [3:0]        cfgOpMode,
  input  logic [3:0]        shKeySize,
  input  logic [3:0]        shOpMode,
  output logic              inReady,
  output logic              passData,
  output logic              firstBeat,
  output strobe_t           st,
  output logic              protoErr,
  output logic              malformErr
);
  state_t            state, stateNext;
  logic [FLAG_W-1:0] flagsQ, flags;
  logic [CNT_W-1:0]  cntQ, cnt, ivBase, keyBase, keyCnt, total, keyOff;
  logic [CNT_W-1:0]  keyStart, limit;
  logic [3:0]        keySize, opMode;
  logic              errQ, beat, inCtrl, tooMany, badNow, opOk, stray;
  logic              protoNext, malformNext;

  assign firstBeat = (state == S_IDLE) && inSop;
  assign inCtrl    = (firstBeat && inType[FL_CTRL]) || (state == S_CTRL);
  assign passData  = (firstBeat && !inType[FL_CTRL] && cfgValid) || (state == S_DATA);
  assign inReady   = passData ? outReady : 1'b1;
  assign beat      = inValid && inReady;
  assign stray     = (state == S_IDLE) && inValid && !inSop;

  assign flags = (state == S_IDLE) ? inType : flagsQ;
  assign cnt   = (state == S_IDLE) ? '0 : cntQ;

  // section layout implied by the flags
  always_comb begin
    keySize  = (cnt == '0) ? cfgKeySize : shKeySize;
    opMode   = (cnt == '0) ? cfgOpMode  : shOpMode;
    limit    = (keySize == 4'd4 || keySize == 4'd6 || keySize == 4'd8) ? CNT_W'(keySize) : '0;
    keyStart = flags[FL_KEYA] ? '0 : (flags[FL_KEYB] ? CNT_W'(KEYB_SLOT) : CNT_W'(KEYC_SLOT));
    keyCnt   = ((|flags[FL_KEYC:FL_KEYA]) && (limit > keyStart)) ? limit - keyStart : '0;
    ivBase   = flags[FL_CIPHER] ? CNT_W'(2) : '0;
    keyBase  = ivBase + (flags[FL_IV] ? CNT_W'(IV_WORDS) : '0);
    total    = keyBase + keyCnt;
    keyOff   = keyStart + (cnt - keyBase);
    tooMany  = cnt >= total;
    opOk     = (opMode == OPM_ENC) || (opMode == OPM_DEC);
    badNow   = errQ || tooMany || ((cnt + 1'b1) != total);
  end

  always_comb begin
    st = '0;
    if (beat && inCtrl) begin
      st.snap  = (cnt == '0);
      st.wrHdr = flags[FL_CIPHER] && (cnt == '0);
      st.wrLen = flags[FL_CIPHER] && (cnt == CNT_W'(1));
      if (flags[FL_IV] && cnt >= ivBase && cnt < ivBase + CNT_W'(IV_WORDS)) begin
        st.wrIv = 1'b1;
        st.idx  = KIDX_W'(cnt - ivBase);
      end
      if (cnt >= keyBase && cnt < total) begin
        st.wrKey = 1'b1;
        st.idx   = KIDX_W'(keyOff);
      end
      st.commit = inEop && !badNow && opOk;
    end
  end

  always_comb begin
    protoNext   = 1'b0;
    malformNext = stray;
    stateNext   = state;
    if (beat) begin
      if (inCtrl && inEop) begin
        malformNext = badNow;
        protoNext   = !badNow && !opOk;
      end
      if (firstBeat && !inType[FL_CTRL] && !cfgValid) protoNext = 1'b1;
      if (firstBeat) begin
        if (inEop)                  stateNext = S_IDLE;
        else if (inType[FL_CTRL])   stateNext = S_CTRL;
        else if (cfgValid)          stateNext = S_DATA;
        else                        stateNext = S_DROP;
      end else if (state != S_IDLE && inEop) begin
        stateNext = S_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      flagsQ     <= '0;
      cntQ       <= '0;
      errQ       <= 1'b0;
      protoErr   <= 1'b0;
      malformErr <= 1'b0;
    end else begin
      state      <= stateNext;
      protoErr   <= protoNext;
      malformErr <= malformNext;
      if (beat && firstBeat) flagsQ <= inType;
      if (beat && inCtrl) begin
        cntQ <= (&cnt) ? cnt : cnt + 1'b1;
        errQ <= ((state == S_IDLE) ? 1'b0 : errQ) | tooMany;
      end
    end
  end
endmodule

// File: rtl/ctrldec_dp.sv
module ctrldec_dp
  import ctrldec_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [WORD_W-1:0]             inData,
  input  strobe_t                       st,
  output logic                          cfgValid,
  output logic [WORD_W-1:0]             cfgHdr,
  output logic [WORD_W-1:0]             cfgLen,
  output logic [IV_WORDS*WORD_W-1:0]    cfgIvFlat,
  output logic [KEY_WORDS*WORD_W-1:0]   cfgKeyFlat,
  output logic [3:0]                    shKeySize,
  output logic [3:0]                    shOpMode
);
  logic [WORD_W-1:0] shHdr, shLen, nHdr, nLen;
  logic [WORD_W-1:0] shIv[IV_WORDS],   nIv[IV_WORDS],   cIv[IV_WORDS];
  logic [WORD_W-1:0] shKey[KEY_WORDS], nKey[KEY_WORDS], cKey[KEY_WORDS];

  assign shKeySize = shHdr[KSZ_LO +: 4];
  assign shOpMode  = shHdr[OPM_LO +: 4];

  // next shadow contents: snapshot of active config, then this beat's write
  always_comb begin
    nHdr = st.snap ? cfgHdr : shHdr;
    nLen = st.snap ? cfgLen : shLen;
    for (int i = 0; i < IV_WORDS; i++)  nIv[i]  = st.snap ? cIv[i]  : shIv[i];
    for (int i = 0; i < KEY_WORDS; i++) nKey[i] = st.snap ? cKey[i] : shKey[i];
    if (st.wrHdr) nHdr = inData;
    if (st.wrLen) nLen = inData;
    if (st.wrIv)  nIv[st.idx[VIDX_W-1:0]] = inData;
    if (st.wrKey) nKey[st.idx] = inData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shHdr <= '0; shLen <= '0; cfgHdr <= '0; cfgLen <= '0; cfgValid <= 1'b0;
      for (int i = 0; i < IV_WORDS; i++)  begin shIv[i]  <= '0; cIv[i]  <= '0; end
      for (int i = 0; i < KEY_WORDS; i++) begin shKey[i] <= '0; cKey[i] <= '0; end
    end else begin
      shHdr <= nHdr;
      shLen <= nLen;
      shIv  <= nIv;
      shKey <= nKey;
      if (st.commit) begin
        cfgHdr   <= nHdr;
        cfgLen   <= nLen;
        cIv      <= nIv;
        cKey     <= nKey;
        cfgValid <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < IV_WORDS; g++) begin : g_iv
    assign cfgIvFlat[g*WORD_W +: WORD_W] = cIv[g];
  end
  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_key
    assign cfgKeyFlat[g*WORD_W +: WORD_W] = cKey[g];
  end
endmodule

// File: rtl/ctrlpkt_decoder.sv
module ctrlpkt_decoder
  import ctrldec_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output logic          inReady,
  input  logic          inSop,
  input  logic          inEop,
  input  logic [9:0]    inType,
  input  logic [31:0]   inData,
  output logic          outValid,
  input  logic          outReady,
  output logic          outSop,
  output logic          outEop,
  output logic [31:0]   outData,
  output logic [7:0]    outProcId,
  output logic          cfgValid,
  output logic [31:0]   cfgHeader,
  output logic [15:0]   cfgAlgLen,
  output logic [15:0]   cfgHdrLen,
  output logic          cfgDecrypt,
  output logic [127:0]  cfgIv,
  output logic [255:0]  cfgKey,
  output logic          protoErr,
  output logic          malformErr
);
  strobe_t     st;
  logic        passData, firstBeat;
  logic [3:0]  shKeySize, shOpMode;
  logic [31:0] cfgLen;

  ctrldec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inType(inType), .outReady(outReady), .cfgValid(cfgValid),
    .cfgKeySize(cfgHeader[KSZ_LO +: 4]), .cfgOpMode(cfgHeader[OPM_LO +: 4]),
    .shKeySize(shKeySize), .shOpMode(shOpMode), .inReady(inReady),
    .passData(passData), .firstBeat(firstBeat), .st(st),
    .protoErr(protoErr), .malformErr(malformErr)
  );

  ctrldec_dp u_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .st(st), .cfgValid(cfgValid),
    .cfgHdr(cfgHeader), .cfgLen(cfgLen), .cfgIvFlat(cfgIv), .cfgKeyFlat(cfgKey),
    .shKeySize(shKeySize), .shOpMode(shOpMode)
  );

  assign outValid   = passData && inValid;
  assign outSop     = firstBeat;
  assign outEop     = inEop;
  assign outData    = inData;
  assign outProcId  = cfgHeader[7:0];
  assign cfgAlgLen  = cfgLen[15:0];
  assign cfgHdrLen  = cfgLen[31:16];
  assign cfgDecrypt = cfgHeader[OPM_LO +: 4] == OPM_DEC;
endmodule

// File: rtl/ctrldec_checker.sv
module ctrldec_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inReady,
  input logic        inEop,
  input logic [31:0] inData,
  input logic        outValid,
  input logic [31:0] outData,
  input logic        cfgValid,
  input logic [31:0] cfgHeader,
  input logic        protoErr,
  input logic        malformErr
);
  AST_FWD_SAME_WORD: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (inValid && outData == inData)); // R1
  AST_CFG_ATOMIC: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady && inEop) |=> $stable(cfgHeader)); // R6
  AST_OPMODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |-> (cfgHeader[31:28] == 4'h1 || cfgHeader[31:28] == 4'h3)); // R7
  AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> cfgValid); // R7
  AST_NOCFG_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !cfgValid |-> !outValid); // R8
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(protoErr && malformErr)); // R6
endmodule

bind ctrlpkt_decoder ctrldec_checker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inEop(inEop),
  .inData(inData), .outValid(outValid), .outData(outData), .cfgValid(cfgValid),
  .cfgHeader(cfgHeader), .protoErr(protoErr), .malformErr(malformErr)
);

// File: tb/ctrlpkt_decoder_tb.sv
module ctrlpkt_decoder_tb;
  logic clk = 0, rstN = 0;
  logic inValid = 0, inSop = 0, inEop = 0, outReady = 1;
  logic [9:0] inType = '0;
  logic [31:0] inData = '0;
  logic inReady, outValid, outSop, outEop, cfgValid, cfgDecrypt, protoErr, malformErr;
  logic [31:0] outData, cfgHeader;
  logic [7:0] outProcId;
  logic [15:0] cfgAlgLen, cfgHdrLen;
  logic [127:0] cfgIv;
  logic [255:0] cfgKey;

  ctrlpkt_decoder u_dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errs = 0;
  int pCnt = 0, mCnt = 0, expPro = 0, expMal = 0;
  logic [31:0] txW[24];
  logic [31:0] rxW[24];
  logic rxS[24], rxE[24];
  logic [7:0] rxPid[24];
  int rxN = 0;
  logic [31:0] mHdr = '0, mLen = '0;
  logic [31:0] mIv[4], mKey[8];
  logic mValid = 0;

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: 1 ns before each rising edge
  always begin
    @(negedge clk); #3;
    if (outValid && outReady && rxN < 24) begin
      rxW[rxN] = outData; rxS[rxN] = outSop; rxE[rxN] = outEop; rxPid[rxN] = outProcId;
      rxN++;
    end
    if (protoErr) pCnt++;
    if (malformErr) mCnt++;
  end

  function automatic int keyLim(input logic [3:0] ks);
    return (ks == 4 || ks == 6 || ks == 8) ? int'(ks) : 0;
  endfunction

  function automatic int pktLen(input logic [9:0] ty, input logic [31:0] hdr);
    int st, kc;
    st = ty[4] ? 0 : (ty[5] ? 4 : 6);
    kc = (|ty[6:4] && keyLim(hdr[23:20]) > st) ? keyLim(hdr[23:20]) - st : 0;
    return (ty[1] ? 2 : 0) + (ty[3] ? 4 : 0) + kc;
  endfunction

  task automatic sendPkt(input logic [9:0] ty, input int n, input bit randRdy);
    int i = 0;
    while (i < n) begin
      @(negedge clk);
      inValid = 1; inSop = (i == 0); inEop = (i == n - 1); inData = txW[i];
      inType = (i == 0) ? ty : '0;
      outReady = randRdy ? (($urandom % 4) != 0) : 1'b1;
      #3;
      if (ty[0]) begin
        check(cfgHeader == mHdr, "R6 config unchanged mid-packet", cfgHeader, mHdr);
        check(inReady && !outValid, "R9 control packet hidden", {inReady, outValid}, 2'b10);
      end
      if (inReady) i++;
    end
    @(negedge clk);
    inValid = 0; inSop = 0; inEop = 0; outReady = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic checkCfg(input string tag);
    logic [127:0] eIv;
    logic [255:0] eKey;
    for (int k = 0; k < 4; k++) eIv[32*k +: 32] = mIv[k];
    for (int k = 0; k < 8; k++) eKey[32*k +: 32] = mKey[k];
    check(cfgValid == mValid, {tag, " R7 cfgValid"}, cfgValid, mValid);
    check(cfgHeader == mHdr, {tag, " R2 header"}, cfgHeader, mHdr);
    check({cfgHdrLen, cfgAlgLen} == mLen, {tag, " R2 length word"}, {cfgHdrLen, cfgAlgLen}, mLen);
    check(cfgIv == eIv, {tag, " R3 iv"}, cfgIv, eIv);
    check(cfgKey == eKey, {tag, " R4 R5 key"}, cfgKey, eKey);
    check(cfgDecrypt == (mHdr[31:28] == 3), {tag, " R7 decrypt"}, cfgDecrypt, mHdr[31:28] == 3);
    check(pCnt == expPro, {tag, " R7 R8 protoErr count"}, pCnt, expPro);
    check(mCnt == expMal, {tag, " R6 R11 malformErr count"}, mCnt, expMal);
  endtask

  task automatic ctrlPkt(input logic [9:0] ty, input int n, input string tag);
    logic [31:0] h;
    int st, kc, base;
    h = ty[1] ? txW[0] : mHdr;
    st = ty[4] ? 0 : (ty[5] ? 4 : 6);
    kc = (|ty[6:4] && keyLim(h[23:20]) > st) ? keyLim(h[23:20]) - st : 0;
    base = (ty[1] ? 2 : 0) + (ty[3] ? 4 : 0);
    sendPkt(ty, n, 0);
    if (n != base + kc) expMal++;
    else if (h[31:28] != 1 && h[31:28] != 3) expPro++;
    else begin
      mHdr = h;
      if (ty[1]) mLen = txW[1];
      if (ty[3]) for (int k = 0; k < 4; k++) mIv[k] = txW[(ty[1] ? 2 : 0) + k];
      for (int k = 0; k < kc; k++) mKey[st + k] = txW[base + k];
      mValid = 1;
    end
    checkCfg(tag);
  endtask

  task automatic dataPkt(input int n, input string tag);
    rxN = 0;
    sendPkt(10'h000, n, 1);
    if (!mValid) begin
      expPro++;
      check(rxN == 0, {tag, " R8 dropped"}, rxN, 0);
      check(pCnt == expPro, {tag, " R8 protoErr"}, pCnt, expPro);
    end else begin
      check(rxN == n, {tag, " R1 word count"}, rxN, n);
      for (int k = 0; k < n && k < rxN; k++) begin
        check(rxW[k] == txW[k], {tag, " R1 data"}, rxW[k], txW[k]);
        check(rxS[k] == (k == 0) && rxE[k] == (k == n - 1), {tag, " R1 markers"},
              {rxS[k], rxE[k]}, {k == 0, k == n - 1});
        check(rxPid[k] == mHdr[7:0], {tag, " R1 process id"}, rxPid[k], mHdr[7:0]);
      end
    end
  endtask

  function automatic logic [31:0] mkHdr(input logic [3:0] opm, input logic [3:0] ks);
    logic [31:0] h;
    h = $urandom;
    h[31:28] = opm; h[23:20] = ks; h[26:24] = 3'h2;
    return h;
  endfunction

  initial begin
    #(8 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 4; k++) mIv[k] = '0;
    for (int k = 0; k < 8; k++) mKey[k] = '0;
    repeat (3) @(negedge clk);
    check(!cfgValid && !outValid && !protoErr && !malformErr && cfgKey == '0 && cfgHeader == '0,
          "R10 reset state", {cfgValid, outValid, protoErr, malformErr}, 4'b0);
    rstN = 1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < 3; k++) txW[k] = $urandom;
    dataPkt(3, "no-config");

    @(negedge clk); inValid = 1; inSop = 0; inData = 32'hdead;
    @(negedge clk); inValid = 0;
    repeat (3) @(negedge clk);
    expMal++;
    check(mCnt == expMal, "R11 stray word", mCnt, expMal);

    txW[0] = mkHdr(4'h1, 4'h4); txW[1] = 32'h0010_0040;
    ctrlPkt(10'h003, 2, "header only");
    for (int k = 0; k < 8; k++) txW[k] = $urandom;
    txW[0] = mkHdr(4'h3, 4'h4);
    ctrlPkt(10'h01b, 10, "iv+key slot0");
    for (int k = 0; k < 4; k++) txW[k] = $urandom;
    ctrlPkt(10'h061, 0 + pktLen(10'h061, mHdr), "slot4 start size4 no words");
    txW[0] = mkHdr(4'h1, 4'h8); txW[1] = $urandom;
    for (int k = 2; k < 6; k++) txW[k] = $urandom;
    ctrlPkt(10'h063, 6, "R4 slot4 beats slot6");
    txW[0] = mkHdr(4'h1, 4'h6); txW[1] = $urandom;
    ctrlPkt(10'h043, 2, "R5 slot6 size6 zero keys");
    for (int k = 0; k < 8; k++) txW[k] = $urandom;
    txW[0] = mkHdr(4'h3, 4'h6);
    ctrlPkt(10'h013, 8, "R5 size6 from slot0");
    for (int k = 0; k < 9; k++) txW[k] = $urandom;
    txW[0] = mkHdr(4'h1, 4'h6);
    ctrlPkt(10'h013, 9, "R6 one word long");
    ctrlPkt(10'h013, 7, "R6 one word short");
    txW[0] = mkHdr(4'h2, 4'h4);
    ctrlPkt(10'h003, 2, "R7 bad op mode");
    txW[0] = mkHdr(4'h1, 4'h8);
    ctrlPkt(10'h387, 2, "R6 auth flags add no words");

    for (int r = 0; r < 40; r++) begin
      if ($urandom % 2) begin
        int n;
        n = 1 + $urandom % 12;
        for (int k = 0; k < n; k++) txW[k] = $urandom;
        dataPkt(n, "random data");
      end else begin
        logic [9:0] ty;
        logic [3:0] ks, opm;
        int n;
        ty = 10'($urandom) | 10'h001;
        if ($urandom % 4 != 0) ty[1] = 1'b1;
        ks = ($urandom % 5 == 0) ? 4'h5 : 4'(4 + 2 * ($urandom % 3));
        opm = ($urandom % 6 == 0) ? 4'h2 : (($urandom % 2) ? 4'h1 : 4'h3);
        for (int k = 0; k < 16; k++) txW[k] = $urandom;
        if (ty[1]) txW[0] = mkHdr(opm, ks);
        n = pktLen(ty, ty[1] ? txW[0] : mHdr);
        if ($urandom % 6 == 0) n = n + 1;
        else if ($urandom % 6 == 0 && n > 1) n = n - 1;
        if (n == 0) n = 1;
        ctrlPkt(ty, n, "random control");
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule